// File: doc/BRIEF.md
# Write-through valid/invalid snooping data cache

This block is a small direct-mapped data cache for one processor that shares a snooping bus with other caching agents. Each line is either valid or invalid, and nothing else. Loads that find a valid line with a matching tag are answered locally and never reach the bus. Loads that miss fetch the word through a bus read and install it. Every store goes out on the bus as a memory write, whether or not the line is present. A store that hits also updates the local copy. A store that misses leaves the cache contents unchanged.

Coherence relies only on the snoop port. When another agent's write is seen on the bus to an address this cache holds, the local copy is invalidated. Any number of caches may then hold the same line valid until the next write. The bus carries one transaction at a time, granted by an external arbiter. The processor issues one request at a time and waits for its response before sending the next. A read miss takes its data in the cycle it is granted, so it observes every write that was ordered on the bus before it.

Top module: `vi_wt_cache`

## Requirements
- R1: After reset every line is invalid: `cpu_req_ready_o` is 1, `bus_req_o` and `cpu_rsp_valid_o` are 0, and the first load to any address misses.
- R2: A load that hits produces `cpu_rsp_valid_o` one cycle after acceptance, with the cached word on `cpu_rsp_rdata_o`. `bus_req_o` does not rise for it.
- R3: A load that misses raises `bus_req_o` with `bus_we_o`=0 and the load address on `bus_addr_o`. In the grant cycle it captures `bus_rdata_i`. It responds with that word one cycle after the grant and installs the line, so a repeat load to the same address then hits.
- R4: Every accepted store raises `bus_req_o` with `bus_we_o`=1, the store address and the store data, whatever the state of the line. It responds one cycle after the grant.
- R5: A store that misses does not install a line: a later load to that address misses and returns the value now in memory.
- R6: A store that hits a line which is still valid at its grant writes the new data into that line, so later loads hit and return it.
- R7: A snoop with `snoop_valid_i`=1 and `snoop_we_i`=1 whose address matches a valid line invalidates that line. A snoop with `snoop_we_i`=0, or a snoop write to the same index with a different tag, leaves the line valid. A store that is pending while its line is invalidated by a snoop does not re-validate the line.
- R8: A snoop write to the same address in the cycle a load is accepted takes priority: the load is handled as a miss.
- R9: While not granted, `bus_req_o` stays high with `bus_addr_o` and `bus_we_o` unchanged. A read miss returns the memory value at its grant, including writes by others while it waited.
- R10: `cpu_req_ready_o` is 0 from acceptance until the response. `cpu_rsp_valid_o` is a single-cycle pulse per request.
- R11: The line index is the low 3 address bits and the tag is the rest. Filling an index replaces the previous tag there, so the earlier address misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_valid_i | input | 1 | Processor request present |
| cpu_req_ready_o | output | 1 | Cache can accept a request |
| cpu_req_we_i | input | 1 | 1 = store, 0 = load |
| cpu_req_addr_i | input | ADDR_W | Word address |
| cpu_req_wdata_i | input | DATA_W | Store data |
| cpu_rsp_valid_o | output | 1 | Request completed (one cycle) |
| cpu_rsp_rdata_o | output | DATA_W | Load result |
| bus_req_o | output | 1 | Bus request to arbiter |
| bus_gnt_i | input | 1 | Grant; transaction happens this cycle |
| bus_we_o | output | 1 | 1 = memory write, 0 = memory read |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_rdata_i | input | DATA_W | Bus read data, valid in grant cycle |
| snoop_valid_i | input | 1 | Another agent's transaction is on the bus |
| snoop_we_i | input | 1 | Snooped transaction is a write |
| snoop_addr_i | input | ADDR_W | Snooped address |

## Verification
The hardest situations to reach are a snoop write that races a local access. One case is a snoop in the very cycle a load is looked up. The other is a snoop that lands while a store or read miss is waiting for grant. The stimulus table gives each vector a grant delay and a snoop cycle counted from acceptance. This places a foreign write exactly on the acceptance edge, or inside the wait window before grant. A follow-up load then shows through its bus activity whether the line survived.

// File: rtl/vi_pkg.sv
package vi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } vi_state_e;
endpackage

// File: rtl/vi_tag_array.sv
module vi_tag_array #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             snp_en_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic [TAG_W-1:0] snp_tag_i
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]            valid_q;
  logic [LINES-1:0][TAG_W-1:0] tag_q;
  logic [LINES-1:0]            kill;

  // snoop write beats a fill or a lookup landing on the same line
  for (genvar i = 0; i < LINES; i++) begin : g_kill
    assign kill[i] = snp_en_i && (snp_idx_i == IDX_W'(i)) &&
                     ((valid_q[i] && (tag_q[i] == snp_tag_i)) ||
                      (fill_en_i && (fill_idx_i == IDX_W'(i)) && (fill_tag_i == snp_tag_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_en_i && (fill_idx_i == IDX_W'(i))) begin
          tag_q[i]   <= fill_tag_i;
          valid_q[i] <= !kill[i];
        end else if (kill[i]) begin
          valid_q[i] <= 1'b0;
        end
      end
    end
  end

  assign lk_hit_o = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i) && !kill[lk_idx_i];
endmodule

// File: rtl/vi_data_array.sv
module vi_data_array #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/vi_ctrl.sv
module vi_ctrl import vi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] lk_addr_o,
  input  logic              lk_hit_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              fill_en_o,
  output logic              dwr_en_o,
  output logic [DATA_W-1:0] dwr_data_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  vi_state_e         state_q, state_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              accept, load_hit, granted;

  assign accept   = (state_q == ST_IDLE) && req_valid_i;
  assign load_hit = accept && !req_we_i && lk_hit_i;
  assign granted  = (state_q == ST_BUS) && bus_gnt_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = load_hit ? ST_RESP : ST_BUS;
      ST_BUS:  if (bus_gnt_i) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        we_q    <= req_we_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (load_hit)             rdata_q <= line_data_i;
      else if (granted && !we_q) rdata_q <= bus_rdata_i;
    end
  end

  assign lk_addr_o   = (state_q == ST_IDLE) ? req_addr_i : addr_q;
  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_rdata_o = rdata_q;

  // read fill installs; store updates only a line still valid at grant
  assign fill_en_o  = granted && !we_q;
  assign dwr_en_o   = granted && (!we_q || lk_hit_i);
  assign dwr_data_o = we_q ? wdata_q : bus_rdata_i;

  assign bus_req_o   = (state_q == ST_BUS);
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
endmodule

// File: rtl/vi_wt_cache.sv
module vi_wt_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_valid_i,
  output logic              cpu_req_ready_o,
  input  logic              cpu_req_we_i,
  input  logic [ADDR_W-1:0] cpu_req_addr_i,
  input  logic [DATA_W-1:0] cpu_req_wdata_i,
  output logic              cpu_rsp_valid_o,
  output logic [DATA_W-1:0] cpu_rsp_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snoop_valid_i,
  input  logic              snoop_we_i,
  input  logic [ADDR_W-1:0] snoop_addr_i
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] lk_addr;
  logic              lk_hit, fill_en, dwr_en, snp_en;
  logic [DATA_W-1:0] line_data, dwr_data;

  assign snp_en = snoop_valid_i && snoop_we_i;

  vi_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_idx_i   (lk_addr[IDX_W-1:0]),
    .lk_tag_i   (lk_addr[ADDR_W-1:IDX_W]),
    .lk_hit_o   (lk_hit),
    .fill_en_i  (fill_en),
    .fill_idx_i (lk_addr[IDX_W-1:0]),
    .fill_tag_i (lk_addr[ADDR_W-1:IDX_W]),
    .snp_en_i   (snp_en),
    .snp_idx_i  (snoop_addr_i[IDX_W-1:0]),
    .snp_tag_i  (snoop_addr_i[ADDR_W-1:IDX_W])
  );

  vi_data_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (dwr_en),
    .wr_idx_i  (lk_addr[IDX_W-1:0]),
    .wr_data_i (dwr_data),
    .rd_idx_i  (lk_addr[IDX_W-1:0]),
    .rd_data_o (line_data)
  );

  vi_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (cpu_req_valid_i),
    .req_we_i    (cpu_req_we_i),
    .req_addr_i  (cpu_req_addr_i),
    .req_wdata_i (cpu_req_wdata_i),
    .req_ready_o (cpu_req_ready_o),
    .rsp_valid_o (cpu_rsp_valid_o),
    .rsp_rdata_o (cpu_rsp_rdata_o),
    .lk_addr_o   (lk_addr),
    .lk_hit_i    (lk_hit),
    .line_data_i (line_data),
    .fill_en_o   (fill_en),
    .dwr_en_o    (dwr_en),
    .dwr_data_o  (dwr_data),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i)
  );
endmodule

// File: rtl/vi_wt_cache_chk.sv
module vi_wt_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_valid_i,
  input logic              cpu_req_ready_o,
  input logic              cpu_req_we_i,
  input logic [ADDR_W-1:0] cpu_req_addr_i,
  input logic [DATA_W-1:0] cpu_req_wdata_i,
  input logic              cpu_rsp_valid_o,
  input logic [DATA_W-1:0] cpu_rsp_rdata_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic [DATA_W-1:0] bus_rdata_i
);
  p_store_to_bus_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_valid_i && cpu_req_ready_o && cpu_req_we_i) |=>
      (bus_req_o && bus_we_o && bus_addr_o == $past(cpu_req_addr_i) &&
       bus_wdata_o == $past(cpu_req_wdata_i)));

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  p_gnt_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i) |=> (cpu_rsp_valid_o && !bus_req_o));

  p_miss_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && !bus_we_o) |=> (cpu_rsp_rdata_o == $past(bus_rdata_i)));

  p_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o || cpu_rsp_valid_o) |-> !cpu_req_ready_o);

  p_rsp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rsp_valid_o |=> !cpu_rsp_valid_o);

  p_load_path_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_valid_i && cpu_req_ready_o && !cpu_req_we_i) |=>
      $onehot({cpu_rsp_valid_o, bus_req_o}));
endmodule

bind vi_wt_cache vi_wt_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cpu_req_valid_i (cpu_req_valid_i),
  .cpu_req_ready_o (cpu_req_ready_o),
  .cpu_req_we_i    (cpu_req_we_i),
  .cpu_req_addr_i  (cpu_req_addr_i),
  .cpu_req_wdata_i (cpu_req_wdata_i),
  .cpu_rsp_valid_o (cpu_rsp_valid_o),
  .cpu_rsp_rdata_o (cpu_rsp_rdata_o),
  .bus_req_o       (bus_req_o),
  .bus_gnt_i       (bus_gnt_i),
  .bus_we_o        (bus_we_o),
  .bus_addr_o      (bus_addr_o),
  .bus_wdata_o     (bus_wdata_o),
  .bus_rdata_i     (bus_rdata_i)
);

// File: tb/sim_vi_wt_cache.sv
`timescale 1ns/1ps
module sim_vi_wt_cache;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cpu_req_valid_i = 1'b0, cpu_req_we_i = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr_i = '0;
  logic [DATA_W-1:0] cpu_req_wdata_i = '0;
  logic              cpu_req_ready_o, cpu_rsp_valid_o;
  logic [DATA_W-1:0] cpu_rsp_rdata_o;
  logic              bus_req_o, bus_we_o;
  logic              bus_gnt_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [DATA_W-1:0] bus_wdata_o, bus_rdata_i;
  logic              snoop_valid_i = 1'b0, snoop_we_i = 1'b0;
  logic [ADDR_W-1:0] snoop_addr_i = '0;

  logic [DATA_W-1:0] mem [DEPTH];
  int nchk = 0, nfail = 0, snp_cnt = 0;

  always #2.5 clk = ~clk;
  assign bus_rdata_i = mem[bus_addr_o];

  vi_wt_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_valid_i(cpu_req_valid_i), .cpu_req_ready_o(cpu_req_ready_o),
    .cpu_req_we_i(cpu_req_we_i), .cpu_req_addr_i(cpu_req_addr_i),
    .cpu_req_wdata_i(cpu_req_wdata_i), .cpu_rsp_valid_o(cpu_rsp_valid_o),
    .cpu_rsp_rdata_o(cpu_rsp_rdata_o), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
    .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i), .snoop_valid_i(snoop_valid_i), .snoop_we_i(snoop_we_i),
    .snoop_addr_i(snoop_addr_i)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [3:0]  gd;   // grant delay in wait cycles
    logic [3:0]  snc;  // snoop cycle after accept, F = none
    logic        snwe;
    logic [7:0]  sna;
    logic        xb;   // expected bus use
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  1'b0, 8'h10, 32'h0,         4'd0, 4'hF, 1'b0, 8'h00, 1'b1}, // R1 cold miss
    '{4'd2,  1'b0, 8'h10, 32'h0,         4'd0, 4'hF, 1'b0, 8'h00, 1'b0}, // R2 hit
    '{4'd4,  1'b1, 8'h10, 32'h1111_2222, 4'd1, 4'hF, 1'b0, 8'h00, 1'b1}, // R4 store hit
    '{4'd6,  1'b0, 8'h10, 32'h0,         4'd0, 4'hF, 1'b0, 8'h00, 1'b0}, // R6 own write seen
    '{4'd4,  1'b1, 8'h21, 32'h3333_4444, 4'd0, 4'hF, 1'b0, 8'h00, 1'b1}, // R4 store miss
    '{4'd5,  1'b0, 8'h21, 32'h0,         4'd0, 4'hF, 1'b0, 8'h00, 1'b1}, // R5 no allocate
    '{4'd9,  1'b0, 8'h22, 32'h0,         4'd3, 4'd1, 1'b1, 8'h22, 1'b1}, // R9 foreign write while waiting
    '{4'd3,  1'b0, 8'h22, 32'h0,         4'd0, 4'hF, 1'b0, 8'h00, 1'b0}, // R3 filled
    '{4'd7,  1'b0, 8'h21, 32'h0,         4'd0, 4'd0, 1'b1, 8'h10, 1'b0}, // R7 kill other line
    '{4'd7,  1'b0, 8'h10, 32'h0,         4'd0, 4'hF, 1'b0, 8'h00, 1'b1}, // R7 killed line misses
    '{4'd7,  1'b0, 8'h22, 32'h0,         4'd0, 4'd0, 1'b0, 8'h22, 1'b0}, // R7 snoop read
    '{4'd7,  1'b0, 8'h22, 32'h0,         4'd0, 4'hF, 1'b0, 8'h00, 1'b0}, // R7 still valid
    '{4'd8,  1'b0, 8'h22, 32'h0,         4'd0, 4'd0, 1'b1, 8'h22, 1'b1}, // R8 same-cycle snoop
    '{4'd11, 1'b0, 8'h2A, 32'h0,         4'd0, 4'hF, 1'b0, 8'h00, 1'b1}, // R11 conflict
    '{4'd11, 1'b0, 8'h22, 32'h0,         4'd0, 4'hF, 1'b0, 8'h00, 1'b1}, // R11 replaced
    '{4'd11, 1'b0, 8'h2A, 32'h0,         4'd0, 4'hF, 1'b0, 8'h00, 1'b1}, // R11 replaced back
    '{4'd7,  1'b0, 8'h2A, 32'h0,         4'd0, 4'd0, 1'b1, 8'h12, 1'b0}, // R7 other tag
    '{4'd3,  1'b0, 8'h2A, 32'h0,         4'd0, 4'hF, 1'b0, 8'h00, 1'b0}, // R3 still hit
    '{4'd7,  1'b1, 8'h2A, 32'h5555_6666, 4'd2, 4'd1, 1'b1, 8'h2A, 1'b1}, // R7 kill under pending store
    '{4'd5,  1'b0, 8'h2A, 32'h0,         4'd0, 4'hF, 1'b0, 8'h00, 1'b1}, // R5 store did not revive
    '{4'd2,  1'b0, 8'h2A, 32'h0,         4'd0, 4'hF, 1'b0, 8'h00, 1'b0}  // R2 hit again
  };

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R?";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic do_snoop(input logic we, input logic [7:0] a);
    snoop_valid_i = 1'b1;
    snoop_we_i    = we;
    snoop_addr_i  = a;
    if (we) begin
      mem[a] = {8'hC0, 8'(snp_cnt), a, 8'h77};
      snp_cnt++;
    end
  endtask

  task automatic run_op(input logic we, input logic [7:0] a, input logic [31:0] wd,
                        input int gd, input int snc, input logic snwe, input logic [7:0] sna,
                        output logic [31:0] rd, output bit ub, output logic gwe,
                        output logic [7:0] ga, output logic [31:0] gwd, output int lat);
    int c = 0, w = 0;
    bit done = 0, pend = 0;
    logic [7:0] pa = '0;
    logic [31:0] pd = '0;
    ub = 0; rd = '0; gwe = 0; ga = '0; gwd = '0;
    @(negedge clk);
    chk(cpu_req_ready_o == 1'b1, "R10", "ready idle", 32'(cpu_req_ready_o), 32'd1);
    cpu_req_valid_i = 1'b1; cpu_req_we_i = we; cpu_req_addr_i = a; cpu_req_wdata_i = wd;
    if (snc == 0) do_snoop(snwe, sna);
    @(posedge clk);
    while (!done && c < 60) begin
      @(negedge clk);
      c++;
      cpu_req_valid_i = 1'b0; snoop_valid_i = 1'b0; bus_gnt_i = 1'b0;
      if (pend) begin mem[pa] = pd; pend = 0; end
      if (cpu_rsp_valid_o) begin
        rd = cpu_rsp_rdata_o; done = 1;
      end else begin
        if (cpu_req_ready_o) chk(0, "R10", "ready while busy", 32'd1, 32'd0);
        if (bus_req_o) begin
          ub = 1; w++;
          if (w > gd) begin
            bus_gnt_i = 1'b1; gwe = bus_we_o; ga = bus_addr_o; gwd = bus_wdata_o;
            if (bus_we_o) begin pend = 1; pa = bus_addr_o; pd = bus_wdata_o; end
          end else if (snc == c) begin
            do_snoop(snwe, sna);
          end
        end
      end
    end
    if (!done) chk(0, "R10", "no response", 32'(c), 32'd0);
    lat = c;
  endtask

  logic [31:0] rd, gwd;
  logic [7:0]  ga;
  logic        gwe;
  bit          ub;
  int          lat;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = {8'h5A, 8'h00, 8'(i), ~8'(i)};
    repeat (3) @(negedge clk);
    chk(cpu_req_ready_o && !bus_req_o && !cpu_rsp_valid_o, "R1", "reset outputs",
        {29'd0, cpu_req_ready_o, bus_req_o, cpu_rsp_valid_o}, 32'd4);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      run_op(VEC[k].we, VEC[k].addr, VEC[k].wd, int'(VEC[k].gd),
             (VEC[k].snc == 4'hF) ? -1 : int'(VEC[k].snc), VEC[k].snwe, VEC[k].sna,
             rd, ub, gwe, ga, gwd, lat);
      chk(ub == VEC[k].xb, rname(VEC[k].rq), $sformatf("row %0d bus use", k),
          32'(ub), 32'(VEC[k].xb));
      chk(lat == (VEC[k].xb ? int'(VEC[k].gd) + 2 : 1), rname(VEC[k].rq),
          $sformatf("row %0d latency", k), 32'(lat),
          VEC[k].xb ? 32'(VEC[k].gd) + 32'd2 : 32'd1);
      if (VEC[k].we)
        chk(gwe && ga == VEC[k].addr && gwd == VEC[k].wd, "R4",
            $sformatf("row %0d bus write", k), gwd, VEC[k].wd);
      else
        chk(rd == mem[VEC[k].addr], rname(VEC[k].rq),
            $sformatf("row %0d load data", k), rd, mem[VEC[k].addr]);
    end

    // R10: response is a single pulse, ready returns
    @(negedge clk);
    chk(!cpu_rsp_valid_o && cpu_req_ready_o, "R10", "rsp pulse end",
        {30'd0, cpu_rsp_valid_o, cpu_req_ready_o}, 32'd1);

    // R1: reset clears valid lines
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(cpu_req_ready_o && !bus_req_o && !cpu_rsp_valid_o, "R1", "reset again",
        {29'd0, cpu_req_ready_o, bus_req_o, cpu_rsp_valid_o}, 32'd4);
    rst_ni = 1'b1;
    run_op(1'b0, 8'h2A, 32'h0, 0, -1, 1'b0, 8'h00, rd, ub, gwe, ga, gwd, lat);
    chk(ub == 1'b1, "R1", "miss after reset", 32'(ub), 32'd1);
    chk(rd == mem[8'h2A], "R3", "refetch data", rd, mem[8'h2A]);

    // R4/R6: write run to a held line, each store on the bus, last value kept
    run_op(1'b1, 8'h2A, 32'hAAAA_0001, 0, -1, 1'b0, 8'h00, rd, ub, gwe, ga, gwd, lat);
    chk(ub && gwe && gwd == 32'hAAAA_0001, "R4", "run store 1", gwd, 32'hAAAA_0001);
    run_op(1'b1, 8'h2A, 32'hAAAA_0002, 1, -1, 1'b0, 8'h00, rd, ub, gwe, ga, gwd, lat);
    chk(ub && gwe && gwd == 32'hAAAA_0002, "R4", "run store 2", gwd, 32'hAAAA_0002);
    run_op(1'b0, 8'h2A, 32'h0, 0, -1, 1'b0, 8'h00, rd, ub, gwe, ga, gwd, lat);
    chk(!ub && rd == 32'hAAAA_0002, "R6", "hit after write run", rd, 32'hAAAA_0002);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule